// File: doc/BRIEF.md
# Configurable Three-Input Lookup Cell Cluster

This block is a small cluster of programmable logic cells that compute user-defined functions of three signals each, without any processor involvement. Every cell picks each of its three inputs from a small menu of sources (tied low, its own previous output, the output of the next cell up, two shared event lines, its own dedicated pin input, or one of five auxiliary lines). The three selected bits form an index into an 8-bit truth register, and the addressed bit is the raw result.

The raw result can be used directly, passed through a two-flop synchronizer, or passed through a spike filter. The filter only lets a new level through once four successive samples agree. The conditioned value is the cell output whenever the cell and the cluster are both enabled. It reaches the cell's pin output only when the output-enable bit is also set. Software configures the cells through a simple byte-wide write port that addresses one register of one cell per clock. A separate one-bit port sets the cluster-wide enable.

Chaining cells through the link source gives functions of more than three signals, for example a five-bit pattern decoder built from two cells. Selecting feedback gives simple sequential behaviour.

Top module: `lut_cluster`

## Requirements
- R1: With conditioning set to bypass, a cell's output equals truth bit {in2,in1,in0} of its truth register in the same cycle. Value 0x80 gives a three-input AND and 0x96 a three-input XOR.
- R2: Selector value 0x0 forces that input to 0. With input 0 masked, truth value 0x40 is a two-input AND of inputs 1 and 2.
- R3: The selector values are 0x3 and 0x4 for event lines 0 and 1, and 0x5 for the cell's dedicated pin input k (pin_in bit 3*cell+k). Values 0x6, 0x8, 0x9, 0xA and 0xC select auxiliary lines 0 to 4 (aux_in bit 5*cell+line). Values 0x7, 0xB and 0xD to 0xF read as 0.
- R4: Selector value 0x2 reads the current output of the next higher cell without a clock delay. The highest cell reads 0.
- R5: Selector value 0x1 reads the cell's own output as it was one clock earlier.
- R6: Conditioning code 1 (control bits 5:4) delays the raw result by exactly two clock edges.
- R7: Conditioning code 2 changes the output only after four successive edge samples of the raw result agree. The new level appears on the fifth edge. Shorter pulses never reach the output, and the output holds its level between agreements.
- R8: Conditioning code 3 is reserved and drives the output low.
- R9: cell_out is low unless the cell enable (control bit 0) and the cluster enable are both set. While disabled, the synchronizer and filter state clear, so after re-enabling, the sync path shows 0 until two new samples arrive.
- R10: pin_out equals cell_out when output enable (control bit 6) is set, and is low otherwise.
- R11: A write lands on the clock edge where wr_en is high. wr_reg selects the register: 0 is control, 1 holds selector 0 in bits 3:0 and selector 1 in bits 7:4, 2 holds selector 2 in bits 3:0, and 3 is the truth table. Control bit 7 (edge-detect) and bits 3:1 (clock source) have no effect on any output.
- R12: After reset, all registers are zero and every cell_out and pin_out is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cluster clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_cell | input | CELL_W | Cell addressed by the write |
| wr_reg | input | 2 | Register addressed within the cell |
| wr_data | input | 8 | Write data |
| glb_wr_en | input | 1 | Cluster enable write strobe |
| glb_wr_data | input | 1 | New cluster enable value |
| pin_in | input | NUM_CELLS*3 | Dedicated pin inputs, three per cell |
| evt_in | input | 2 | Shared event lines |
| aux_in | input | NUM_CELLS*5 | Auxiliary lines, five per cell |
| cell_out | output | NUM_CELLS | Conditioned, enable-gated cell outputs |
| pin_out | output | NUM_CELLS | Cell outputs gated by output enable |

## Verification
A wrong selector or truth register shows at cell_out in the same cycle in bypass mode, because the path from register to port is purely combinational. A corrupt synchronizer or filter stage appears two or five edges later, as an early, late or missing level change. A stale stage left over from a disabled period shows as a spurious 1 right after re-enable. A broken feedback register breaks the strict alternation of a self-inverting cell on the very next edge.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  localparam int SEL_W     = 4;
  localparam int N_IN      = 3;
  localparam int TRUTH_W   = 1 << N_IN;
  localparam int AUX_LINES = 5;
  localparam int EVT_LINES = 2;
  localparam int DATA_W    = 8;
  localparam int SYNC_DEPTH = 2;

  localparam logic [SEL_W-1:0] SRC_MASK = 4'h0;
  localparam logic [SEL_W-1:0] SRC_FB   = 4'h1;
  localparam logic [SEL_W-1:0] SRC_LINK = 4'h2;
  localparam logic [SEL_W-1:0] SRC_EVT0 = 4'h3;
  localparam logic [SEL_W-1:0] SRC_EVT1 = 4'h4;
  localparam logic [SEL_W-1:0] SRC_PIN  = 4'h5;
  localparam logic [SEL_W-1:0] SRC_AUX0 = 4'h6;
  localparam logic [SEL_W-1:0] SRC_AUX1 = 4'h8;
  localparam logic [SEL_W-1:0] SRC_AUX2 = 4'h9;
  localparam logic [SEL_W-1:0] SRC_AUX3 = 4'hA;
  localparam logic [SEL_W-1:0] SRC_AUX4 = 4'hC;

  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_SEL_LO = 2'd1;
  localparam logic [1:0] REG_SEL_HI = 2'd2;
  localparam logic [1:0] REG_TRUTH  = 2'd3;

  typedef enum logic [1:0] {
    COND_BYPASS = 2'd0,
    COND_SYNC   = 2'd1,
    COND_FILTER = 2'd2,
    COND_RSVD   = 2'd3
  } cond_mode_e;

  typedef struct packed {
    logic       out_en;
    cond_mode_e mode;
    logic       en;
  } cell_ctrl_t;

endpackage

// File: rtl/lut_src_mux.sv
module lut_src_mux
  import lut_cell_pkg::*;
(
  input  logic [SEL_W-1:0]     sel,
  input  logic                 fb,
  input  logic                 link,
  input  logic [EVT_LINES-1:0] evt,
  input  logic                 pin,
  input  logic [AUX_LINES-1:0] aux,
  output logic                 src
);

  always_comb begin
    case (sel)
      SRC_MASK: src = 1'b0;
      SRC_FB:   src = fb;
      SRC_LINK: src = link;
      SRC_EVT0: src = evt[0];
      SRC_EVT1: src = evt[1];
      SRC_PIN:  src = pin;
      SRC_AUX0: src = aux[0];
      SRC_AUX1: src = aux[1];
      SRC_AUX2: src = aux[2];
      SRC_AUX3: src = aux[3];
      SRC_AUX4: src = aux[4];
      default:  src = 1'b0;
    endcase
  end

endmodule

// File: rtl/lut_out_cond.sv
module lut_out_cond
  import lut_cell_pkg::*;
#(
  parameter int FILT_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  cond_mode_e mode,
  input  logic       raw,
  output logic       y
);

  localparam int RUN_W = $clog2(FILT_DEPTH + 1);

  logic [FILT_DEPTH-1:0] chain_q, chain_d;
  logic                  filt_q, filt_d;
  logic                  all_hi, all_lo, chain_ce;
  logic [RUN_W-1:0]      hi_run_q, hi_run_d;

  assign all_hi   = &chain_q;
  assign all_lo   = ~|chain_q;
  assign chain_ce = en | ~all_lo | filt_q;

  always_comb begin
    if (!en) begin
      chain_d = '0;
      filt_d  = 1'b0;
    end else begin
      chain_d = {chain_q[FILT_DEPTH-2:0], raw};
      if (all_hi)      filt_d = 1'b1;
      else if (all_lo) filt_d = 1'b0;
      else             filt_d = filt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      filt_q  <= 1'b0;
    end else if (chain_ce) begin
      chain_q <= chain_d;
      filt_q  <= filt_d;
    end
  end

  always_comb begin
    case (mode)
      COND_BYPASS: y = raw;
      COND_SYNC:   y = chain_q[SYNC_DEPTH-1];
      COND_FILTER: y = filt_q;
      default:     y = 1'b0;
    endcase
  end

  // Run length of high raw samples, used only by the filter check below.
  always_comb begin
    if (!en || !raw)                           hi_run_d = '0;
    else if (hi_run_q != RUN_W'(FILT_DEPTH))   hi_run_d = hi_run_q + 1'b1;
    else                                       hi_run_d = hi_run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_run_q <= '0;
    else        hi_run_q <= hi_run_d;
  end

  // R7: a filtered rise needs a full run of agreeing high samples
  p_filter_min_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_q) |-> ($past(hi_run_q) == RUN_W'(FILT_DEPTH)));

  // R9: disabling clears the conditioning state on the next edge
  p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (chain_q == '0 && !filt_q));

  // R6: the synchronizer path shows the raw value from two edges earlier
  p_sync_delay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(en, 2) && mode == COND_SYNC) |-> (y == $past(raw, 2)));

endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int FILT_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 glb_en,
  input  logic                 wr_en,
  input  logic [1:0]           wr_reg,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [N_IN-1:0]      pin_in,
  input  logic [EVT_LINES-1:0] evt_in,
  input  logic [AUX_LINES-1:0] aux_in,
  input  logic                 link_in,
  output logic                 cell_out,
  output logic                 pin_out
);

  cell_ctrl_t                  ctrl_q, ctrl_d;
  logic [N_IN-1:0][SEL_W-1:0]  sel_q, sel_d;
  logic [TRUTH_W-1:0]          truth_q, truth_d;
  logic                        fb_q;
  logic [N_IN-1:0]             in_vec;
  logic                        raw, eff_en, cond_y;

  always_comb begin
    ctrl_d  = ctrl_q;
    sel_d   = sel_q;
    truth_d = truth_q;
    case (wr_reg)
      REG_CTRL: begin
        ctrl_d.out_en = wr_data[6];
        ctrl_d.mode   = cond_mode_e'(wr_data[5:4]);
        ctrl_d.en     = wr_data[0];
      end
      REG_SEL_LO: begin
        sel_d[0] = wr_data[3:0];
        sel_d[1] = wr_data[7:4];
      end
      REG_SEL_HI: sel_d[2] = wr_data[3:0];
      default:    truth_d  = wr_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      sel_q   <= '0;
      truth_q <= '0;
    end else if (wr_en) begin
      ctrl_q  <= ctrl_d;
      sel_q   <= sel_d;
      truth_q <= truth_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fb_q <= 1'b0;
    else        fb_q <= cell_out;
  end

  for (genvar k = 0; k < N_IN; k++) begin : g_src
    lut_src_mux u_mux (
      .sel  (sel_q[k]),
      .fb   (fb_q),
      .link (link_in),
      .evt  (evt_in),
      .pin  (pin_in[k]),
      .aux  (aux_in),
      .src  (in_vec[k])
    );
  end

  assign raw    = truth_q[in_vec];
  assign eff_en = ctrl_q.en & glb_en;

  lut_out_cond #(.FILT_DEPTH(FILT_DEPTH)) u_cond (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (eff_en),
    .mode  (ctrl_q.mode),
    .raw   (raw),
    .y     (cond_y)
  );

  assign cell_out = eff_en & cond_y;
  assign pin_out  = cell_out & ctrl_q.out_en;

  // R10: the pin is driven only by an enabled, output-enabled cell
  p_pin_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out |-> (ctrl_q.out_en && ctrl_q.en && glb_en));

  // R2: with every input masked the bypass result is truth bit 0
  p_all_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_en && ctrl_q.mode == COND_BYPASS && sel_q == '0) |-> (cell_out == truth_q[0]));

endmodule

// File: rtl/lut_cluster.sv
module lut_cluster
  import lut_cell_pkg::*;
#(
  parameter int NUM_CELLS  = 2,
  parameter int FILT_DEPTH = 4,
  localparam int CELL_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [CELL_W-1:0]              wr_cell,
  input  logic [1:0]                     wr_reg,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           glb_wr_en,
  input  logic                           glb_wr_data,
  input  logic [NUM_CELLS*N_IN-1:0]      pin_in,
  input  logic [EVT_LINES-1:0]           evt_in,
  input  logic [NUM_CELLS*AUX_LINES-1:0] aux_in,
  output logic [NUM_CELLS-1:0]           cell_out,
  output logic [NUM_CELLS-1:0]           pin_out
);

  logic rst_meta_q, rst_sync_n;
  logic glb_en_q, glb_en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign glb_en_d = glb_wr_data;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    glb_en_q <= 1'b0;
    else if (glb_wr_en) glb_en_q <= glb_en_d;
  end

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    logic link_w;
    logic cell_wr;

    if (i == NUM_CELLS - 1) begin : g_top
      assign link_w = 1'b0;
    end else begin : g_mid
      assign link_w = cell_out[i+1];
    end

    assign cell_wr = wr_en && (wr_cell == CELL_W'(i));

    lut_cell #(.FILT_DEPTH(FILT_DEPTH)) u_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .glb_en   (glb_en_q),
      .wr_en    (cell_wr),
      .wr_reg   (wr_reg),
      .wr_data  (wr_data),
      .pin_in   (pin_in[i*N_IN +: N_IN]),
      .evt_in   (evt_in),
      .aux_in   (aux_in[i*AUX_LINES +: AUX_LINES]),
      .link_in  (link_w),
      .cell_out (cell_out[i]),
      .pin_out  (pin_out[i])
    );
  end

  // R9: a cleared cluster enable silences every cell
  p_glb_off_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !glb_en_q |-> (cell_out == '0));

endmodule

// File: tb/sim_lut_cluster.sv
`timescale 1ns/1ps
module sim_lut_cluster;

  localparam int N  = 2;
  localparam int CW = 1;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           wr_en;
  logic [CW-1:0]  wr_cell;
  logic [1:0]     wr_reg;
  logic [7:0]     wr_data;
  logic           glb_wr_en, glb_wr_data;
  logic [N*3-1:0] pin_in;
  logic [1:0]     evt_in;
  logic [N*5-1:0] aux_in;
  logic [N-1:0]   cell_out, pin_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lut_cluster #(.NUM_CELLS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cell(wr_cell), .wr_reg(wr_reg),
    .wr_data(wr_data), .glb_wr_en(glb_wr_en), .glb_wr_data(glb_wr_data),
    .pin_in(pin_in), .evt_in(evt_in), .aux_in(aux_in),
    .cell_out(cell_out), .pin_out(pin_out)
  );

  // {sel2,sel1,sel0}[31:20] truth[19:12] pin[11:9] evt[8:7] aux[6:2] expect[1] pad[0]
  localparam int ROWS = 20;
  localparam logic [31:0] VEC [ROWS] = '{
    {12'h555, 8'h80, 3'b111, 2'b00, 5'b00000, 1'b1, 1'b0}, // R1 AND
    {12'h555, 8'h80, 3'b110, 2'b00, 5'b00000, 1'b0, 1'b0}, // R1 AND
    {12'h555, 8'h96, 3'b100, 2'b00, 5'b00000, 1'b1, 1'b0}, // R1 XOR
    {12'h555, 8'h96, 3'b011, 2'b00, 5'b00000, 1'b0, 1'b0}, // R1 XOR
    {12'h555, 8'h96, 3'b111, 2'b00, 5'b00000, 1'b1, 1'b0}, // R1 XOR
    {12'h550, 8'h40, 3'b111, 2'b00, 5'b00000, 1'b1, 1'b0}, // R2 masked in0
    {12'h550, 8'h40, 3'b101, 2'b00, 5'b00000, 1'b0, 1'b0}, // R2 masked in0
    {12'h003, 8'h02, 3'b000, 2'b01, 5'b00000, 1'b1, 1'b0}, // R3 evt0
    {12'h004, 8'h02, 3'b000, 2'b01, 5'b00000, 1'b0, 1'b0}, // R3 evt1
    {12'h004, 8'h02, 3'b000, 2'b10, 5'b00000, 1'b1, 1'b0}, // R3 evt1
    {12'h006, 8'h02, 3'b000, 2'b00, 5'b00001, 1'b1, 1'b0}, // R3 aux0
    {12'h00C, 8'h02, 3'b000, 2'b00, 5'b10000, 1'b1, 1'b0}, // R3 aux4
    {12'h00A, 8'h02, 3'b000, 2'b00, 5'b10000, 1'b0, 1'b0}, // R3 aux3
    {12'h00A, 8'h02, 3'b000, 2'b00, 5'b01000, 1'b1, 1'b0}, // R3 aux3
    {12'h007, 8'h02, 3'b111, 2'b11, 5'b11111, 1'b0, 1'b0}, // R3 reserved
    {12'h00B, 8'h02, 3'b111, 2'b11, 5'b11111, 1'b0, 1'b0}, // R3 reserved
    {12'h00D, 8'h02, 3'b111, 2'b11, 5'b11111, 1'b0, 1'b0}, // R3 reserved
    {12'h00F, 8'h02, 3'b111, 2'b11, 5'b11111, 1'b0, 1'b0}, // R3 reserved
    {12'h080, 8'h04, 3'b000, 2'b00, 5'b00010, 1'b1, 1'b0}, // R3 aux1 on in1
    {12'h900, 8'h10, 3'b000, 2'b00, 5'b00100, 1'b1, 1'b0}  // R3 aux2 on in2
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wr(input int c, input logic [1:0] r, input logic [7:0] d);
    wr_en   = 1'b1;
    wr_cell = CW'(c);
    wr_reg  = r;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic glb(input logic v);
    glb_wr_en   = 1'b1;
    glb_wr_data = v;
    @(negedge clk);
    glb_wr_en   = 1'b0;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic prev;
    rst_n = 1'b0; wr_en = 1'b0; wr_cell = '0; wr_reg = '0; wr_data = '0;
    glb_wr_en = 1'b0; glb_wr_data = 1'b0; pin_in = '0; evt_in = '0; aux_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12: reset state, even with a full-on truth table reachable only after writes
    pin_in = '1;
    @(negedge clk);
    check("R12 reset cell_out", |cell_out, 1'b0);
    check("R12 reset pin_out", |pin_out, 1'b0);

    glb(1'b1);
    wr(0, 2'd0, 8'h41);

    // R1 R2 R3 table walk
    for (int r = 0; r < ROWS; r++) begin
      wr(0, 2'd1, VEC[r][27:20]);
      wr(0, 2'd2, {4'h0, VEC[r][31:28]});
      wr(0, 2'd3, VEC[r][19:12]);
      pin_in[2:0] = VEC[r][11:9];
      evt_in      = VEC[r][8:7];
      aux_in[4:0] = VEC[r][6:2];
      @(negedge clk);
      check($sformatf("R1 R2 R3 row %0d cell_out", r), cell_out[0], VEC[r][1]);
      check($sformatf("R10 row %0d pin_out", r), pin_out[0], VEC[r][1]);
    end
    evt_in = '0; aux_in = '0;

    // R10 and R11: output enable gating, ignored control fields
    wr(0, 2'd1, 8'h55); wr(0, 2'd2, 8'h05); wr(0, 2'd3, 8'h80);
    pin_in = 6'b000_111;
    wr(0, 2'd0, 8'h01);
    check("R10 no outen cell_out", cell_out[0], 1'b1);
    check("R10 no outen pin_out", pin_out[0], 1'b0);
    wr(0, 2'd0, 8'hCF);
    check("R11 edge/clksrc bits ignored cell_out", cell_out[0], 1'b1);
    check("R11 edge/clksrc bits ignored pin_out", pin_out[0], 1'b1);
    wr(0, 2'd0, 8'h8E);
    check("R11 R9 disabled despite other bits", cell_out[0], 1'b0);

    // R9: cluster enable
    wr(0, 2'd0, 8'h41);
    glb(1'b0);
    check("R9 global off", cell_out[0], 1'b0);
    glb(1'b1);
    check("R9 global on", cell_out[0], 1'b1);

    // R4: link from the next cell, highest cell reads 0
    wr(1, 2'd1, 8'h55); wr(1, 2'd2, 8'h05); wr(1, 2'd3, 8'h80); wr(1, 2'd0, 8'h01);
    wr(0, 2'd2, 8'h02);
    pin_in = 6'b111_111;
    @(negedge clk);
    check("R4 link high", cell_out[0], 1'b1);
    pin_in = 6'b110_111;
    @(negedge clk);
    check("R4 link low", cell_out[0], 1'b0);
    wr(1, 2'd1, 8'h02); wr(1, 2'd2, 8'h00); wr(1, 2'd3, 8'h01);
    check("R4 top cell link reads 0", cell_out[1], 1'b1);
    check("R4 chained through top cell", cell_out[0], 1'b1);
    wr(1, 2'd0, 8'h00);

    // R5: feedback toggles every edge
    wr(0, 2'd1, 8'h01); wr(0, 2'd2, 8'h00); wr(0, 2'd3, 8'h01);
    prev = cell_out[0];
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      check("R5 feedback alternates", cell_out[0], ~prev);
      prev = cell_out[0];
    end

    // R6: synchronizer delay of two edges
    wr(0, 2'd1, 8'h55); wr(0, 2'd2, 8'h05); wr(0, 2'd3, 8'h80);
    pin_in = 6'b000_000;
    wr(0, 2'd0, 8'h51);
    repeat (3) @(negedge clk);
    check("R6 sync idle", cell_out[0], 1'b0);
    pin_in = 6'b000_111;
    @(negedge clk);
    check("R6 sync after one edge", cell_out[0], 1'b0);
    @(negedge clk);
    check("R6 sync after two edges", cell_out[0], 1'b1);

    // R7: spike filter
    pin_in = 6'b000_000;
    wr(0, 2'd0, 8'h61);
    repeat (6) @(negedge clk);
    check("R7 filter idle", cell_out[0], 1'b0);
    pin_in = 6'b000_111;
    repeat (3) @(negedge clk);
    pin_in = 6'b000_000;
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      check("R7 three-cycle spike blocked", cell_out[0], 1'b0);
    end
    pin_in = 6'b000_111;
    repeat (4) @(negedge clk);
    check("R7 not yet after four edges", cell_out[0], 1'b0);
    @(negedge clk);
    check("R7 passes on fifth edge", cell_out[0], 1'b1);
    pin_in = 6'b000_000;
    @(negedge clk);
    pin_in = 6'b000_111;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      check("R7 holds through low glitch", cell_out[0], 1'b1);
    end

    // R8: reserved conditioning code
    wr(0, 2'd0, 8'h71);
    repeat (6) @(negedge clk);
    check("R8 reserved mode low", cell_out[0], 1'b0);
    check("R8 reserved mode pin low", pin_out[0], 1'b0);

    // R9: disabling clears the synchronizer
    wr(0, 2'd0, 8'h51);
    repeat (3) @(negedge clk);
    check("R9 sync settled high", cell_out[0], 1'b1);
    wr(0, 2'd0, 8'h50);
    check("R9 cell disabled low", cell_out[0], 1'b0);
    repeat (3) @(negedge clk);
    wr(0, 2'd0, 8'h51);
    check("R9 cleared at re-enable", cell_out[0], 1'b0);
    @(negedge clk);
    check("R9 one sample after re-enable", cell_out[0], 1'b0);
    @(negedge clk);
    check("R9 two samples after re-enable", cell_out[0], 1'b1);

    summary();
  end

endmodule